// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block performs the integer add/subtract family on byte, 16-bit or 32-bit operands picked by a size code. It covers plain add, add with incoming carry, subtract, subtract with incoming borrow, compare, increment, decrement and negate. Along with the result it computes a six-bit status vector: carry, parity, adjust, zero, sign and overflow. It also reports which of those bits the operation updated.

One operation is accepted on any cycle where `op_valid` is high. Exactly one cycle later the unit presents the registered result, a one-cycle `res_valid` pulse and a result-write strobe. At the same time it presents the new flag vector and its update mask. The flag vector is held inside the unit, so a later increment or decrement passes the earlier carry through untouched. Multi-word arithmetic is done by feeding the previous carry back on `carry_in` for the next add-with-carry or subtract-with-borrow.

Top module: `int_alu_flags`

## Requirements
- R1: `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width have no effect on any output. `res_data` is zero above the selected width.
- R2: `op_code` encodings are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 increment, 6 decrement, 7 negate. Each produces the width-truncated arithmetic value of `src_a` and `src_b`.
- R3: `flag_out` bit 0 is carry. It is set when the operation carries or borrows out of the top bit of the selected width, and cleared otherwise.
- R4: `flag_out` bit 1 is parity. It is set when bits 7..0 of the result hold an even number of ones, at every width.
- R5: `flag_out` bit 2 is adjust. It is set on a carry or borrow out of result bit 3.
- R6: `flag_out` bit 3 is zero. It is set when the width-truncated result is 0. Bit 4 is sign and equals the top bit of the result at the selected width.
- R7: `flag_out` bit 5 is overflow. It is set when the exact signed result falls outside the two's-complement range of the selected width.
- R8: Increment and decrement update bits 5..1 and keep carry at its previous value. `flag_wr_mask` is 6'h3E for these two and 6'h3F for every other operation.
- R9: Compare computes `src_a - src_b` and updates all six flags. It leaves `res_wr` low and `res_data` unchanged. For example, 8-bit 254 compared with 17 gives carry 0, overflow 0, sign 1 and zero 0.
- R10: Add-with-carry adds `carry_in`. Subtract-with-borrow subtracts `carry_in`. The other operations ignore `carry_in`.
- R11: Negate computes 0 minus `src_a`. Carry is set unless the operand is 0. Overflow is set only for the most negative value of the width.
- R12: Outputs change on the clock edge after `op_valid`. `res_valid` pulses for that one cycle and `res_wr` pulses with it for operations other than compare. With no operation issued, `flag_out` holds and `flag_wr_mask` is 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for one operation |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand width select |
| src_a | input | 32 | First operand (destination side) |
| src_b | input | 32 | Second operand (source side) |
| carry_in | input | 1 | Incoming carry or borrow for chained operations |
| res_data | output | 32 | Registered result, zero-extended |
| res_wr | output | 1 | Result-write strobe |
| res_valid | output | 1 | One-cycle pulse after an issued operation |
| flag_out | output | 6 | Status vector {overflow, sign, zero, adjust, parity, carry} |
| flag_wr_mask | output | 6 | Flag bits updated by the last operation |

## Verification
The assertions check the following on every cycle:
- The single-cycle issue-to-valid timing.
- That the flags and mask stay quiet between operations.
- That carry is preserved across increment and decrement.
- That compare never writes the result.
- That byte results stay zero-extended.
- That the zero flag agrees with any written result.

The arithmetic itself cannot be shown cycle by cycle; only the bench's sweeps can show it. The bench compares each flag against an independent wide-integer model for:
- the carry and overflow boundaries at each width;
- parity and adjust;
- negate of zero and of the most negative value;
- borrow chaining through `carry_in`.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int FLAGW = 6;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_INC = 3'd5,
        OP_DEC = 3'd6,
        OP_NEG = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_FULL  = 2'd2,
        SZ_FULL2 = 2'd3
    } alu_size_e;

    // packed MSB first: ovf is bit 5, cry is bit 0
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic adj;
        logic par;
        logic cry;
    } alu_flags_t;

    function automatic int unsigned lanes_of(alu_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return LANES;
        endcase
    endfunction

    function automatic int unsigned msb_of(alu_size_e s);
        return lanes_of(s) * 8 - 1;
    endfunction

    function automatic logic [XLEN-1:0] width_mask(alu_size_e s);
        return {XLEN{1'b1}} >> (XLEN - lanes_of(s) * 8);
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) ||
               (op == OP_DEC) || (op == OP_NEG);
    endfunction

    function automatic logic op_uses_cin(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic op_keeps_carry(alu_op_e op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

    function automatic logic op_writes(alu_op_e op);
        return op != OP_CMP;
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
// Masks an operand to the selected width and builds its sign-extended form.
module alu_operand_prep
    import alu_pkg::*;
(
    input  alu_size_e        size_i,
    input  logic [XLEN-1:0]  raw_i,
    output logic [XLEN-1:0]  zext_o,
    output logic [XLEN+1:0]  sext_o
);
    logic [XLEN-1:0] keep;
    logic            sgn;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign keep[k*8 +: 8] = {8{(k < int'(lanes_of(size_i)))}};
    end

    assign zext_o = raw_i & keep;
    assign sgn    = raw_i[msb_of(size_i)];
    assign sext_o = {{2{sgn}}, zext_o | ({XLEN{sgn}} & ~keep)};

endmodule

// File: rtl/alu_arith.sv
// Selects the adder inputs per operation and forms unsigned and signed sums.
module alu_arith
    import alu_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [XLEN-1:0]  a_z_i,
    input  logic [XLEN+1:0]  a_s_i,
    input  logic [XLEN-1:0]  b_z_i,
    input  logic [XLEN+1:0]  b_s_i,
    input  logic             cin_i,
    output logic [XLEN+1:0]  usum_o,
    output logic [XLEN+1:0]  ssum_o,
    output logic             xy4_o
);
    logic [XLEN-1:0] x_z, y_z;
    logic [XLEN+1:0] x_s, y_s, ux, uy, cc;
    logic            c, sub;

    always_comb begin
        x_z = a_z_i;
        x_s = a_s_i;
        y_z = b_z_i;
        y_s = b_s_i;
        c   = op_uses_cin(op_i) & cin_i;
        sub = op_is_sub(op_i);
        case (op_i)
            OP_INC, OP_DEC: begin
                y_z = XLEN'(1);
                y_s = (XLEN+2)'(1);
            end
            OP_NEG: begin
                x_z = '0;
                x_s = '0;
                y_z = a_z_i;
                y_s = a_s_i;
            end
            default: ;
        endcase
    end

    assign ux = {2'b00, x_z};
    assign uy = {2'b00, y_z};
    assign cc = {{(XLEN+1){1'b0}}, c};

    assign usum_o = sub ? (ux - uy - cc) : (ux + uy + cc);
    assign ssum_o = sub ? (x_s - y_s - cc) : (x_s + y_s + cc);
    assign xy4_o  = x_z[4] ^ y_z[4];

endmodule

// File: rtl/alu_flag_gen.sv
// Truncates the sum to the selected width and derives the six status flags.
module alu_flag_gen
    import alu_pkg::*;
(
    input  alu_size_e        size_i,
    input  logic [XLEN+1:0]  usum_i,
    input  logic [XLEN+1:0]  ssum_i,
    input  logic             xy4_i,
    output logic [XLEN-1:0]  res_o,
    output alu_flags_t       flags_o
);
    always_comb begin
        int unsigned msb;
        msb          = msb_of(size_i);
        res_o        = usum_i[XLEN-1:0] & width_mask(size_i);
        flags_o.cry  = usum_i[msb + 1];
        flags_o.ovf  = ssum_i[msb + 1] ^ ssum_i[msb];
        flags_o.sgn  = res_o[msb];
        flags_o.zro  = (res_o == '0);
        flags_o.adj  = xy4_i ^ res_o[4];
        flags_o.par  = ~^res_o[7:0];
    end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic              carry_in,
    output logic [XLEN-1:0]   res_data,
    output logic              res_wr,
    output logic              res_valid,
    output logic [FLAGW-1:0]  flag_out,
    output logic [FLAGW-1:0]  flag_wr_mask
);
    alu_op_e          op;
    alu_size_e        sz;
    logic [XLEN-1:0]  a_z, b_z, res_c;
    logic [XLEN+1:0]  a_s, b_s, usum, ssum;
    logic             xy4;
    alu_flags_t       flg_c, flg_next, upd_mask, flags_q, mask_q;
    logic [XLEN-1:0]  result_q;
    logic             valid_q, wr_q;

    assign op = alu_op_e'(op_code);
    assign sz = alu_size_e'(op_size);

    alu_operand_prep u_prep_a (.size_i(sz), .raw_i(src_a), .zext_o(a_z), .sext_o(a_s));
    alu_operand_prep u_prep_b (.size_i(sz), .raw_i(src_b), .zext_o(b_z), .sext_o(b_s));

    alu_arith u_arith (
        .op_i(op), .a_z_i(a_z), .a_s_i(a_s), .b_z_i(b_z), .b_s_i(b_s),
        .cin_i(carry_in), .usum_o(usum), .ssum_o(ssum), .xy4_o(xy4)
    );

    alu_flag_gen u_flags (
        .size_i(sz), .usum_i(usum), .ssum_i(ssum), .xy4_i(xy4),
        .res_o(res_c), .flags_o(flg_c)
    );

    always_comb begin
        flg_next     = flg_c;
        upd_mask     = '1;
        if (op_keeps_carry(op)) begin
            flg_next.cry = flags_q.cry;
            upd_mask.cry = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
            mask_q   <= '0;
            valid_q  <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            valid_q <= op_valid;
            wr_q    <= op_valid && op_writes(op);
            mask_q  <= op_valid ? upd_mask : '0;
            if (op_valid) begin
                flags_q <= flg_next;
                if (op_writes(op)) begin
                    result_q <= res_c;
                end
            end
        end
    end

    assign res_data     = result_q;
    assign res_wr       = wr_q;
    assign res_valid    = valid_q;
    assign flag_out     = flags_q;
    assign flag_wr_mask = mask_q;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic [1:0]  op_size,
    input logic [31:0] res_data,
    input logic        res_wr,
    input logic        res_valid,
    input logic [5:0]  flag_out,
    input logic [5:0]  flag_wr_mask
);
    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R12
    idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (flag_wr_mask == 6'h00));

    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(flag_out));

    // R12
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_wr |-> res_valid);

    // R8
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd5 || op_code == 3'd6)
        |=> (flag_out[0] == $past(flag_out[0])) && !flag_wr_mask[0]);

    // R9
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd4) |=> !res_wr && $stable(res_data));

    // R1
    byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_size == 2'd0) && (op_code != 3'd4) |=> (res_data[31:8] == 24'h0));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        res_wr |-> (flag_out[3] == (res_data == 32'h0)));

endmodule

bind int_alu_flags alu_flags_chk u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .res_data(res_data), .res_wr(res_wr),
    .res_valid(res_valid), .flag_out(flag_out), .flag_wr_mask(flag_wr_mask)
);

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] res_data;
    logic        res_wr, res_valid;
    logic [5:0]  flag_out, flag_wr_mask;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [5:0]  m_flags  = '0;
    logic [31:0] m_result = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu_flags u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .src_a(src_a), .src_b(src_b), .carry_in(carry_in),
        .res_data(res_data), .res_wr(res_wr), .res_valid(res_valid),
        .flag_out(flag_out), .flag_wr_mask(flag_wr_mask)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input int s);
        return (s == 0) ? 8 : (s == 1) ? 16 : 32;
    endfunction

    // Reference arithmetic on wide signed integers
    function automatic void model(input int o, input int s, input longint ar, input longint br,
                                  input int ci, output longint res, output logic [5:0] f);
        int     w    = width_of(s);
        longint m    = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint a    = ar & m;
        longint b    = br & m;
        longint sa   = (a >= half) ? a - (m + 1) : a;
        longint sb   = (b >= half) ? b - (m + 1) : b;
        longint x = a, y = b, sx = sa, sy = sb, c = 0, u, sv;
        bit     sub = 0;
        logic [7:0] lb;
        case (o)
            1: c = ci;
            2, 4: sub = 1;
            3: begin sub = 1; c = ci; end
            5: begin y = 1; sy = 1; end
            6: begin y = 1; sy = 1; sub = 1; end
            7: begin x = 0; sx = 0; y = a; sy = sa; sub = 1; end
            default: ;
        endcase
        u   = sub ? x - y - c : x + y + c;
        sv  = sub ? sx - sy - c : sx + sy + c;
        res = u & m;
        lb  = 8'(res);
        f[0] = (u < 0) || (u > m);
        f[1] = ~^lb;
        f[2] = (((x ^ y ^ res) >> 4) & 1) != 0;
        f[3] = (res == 0);
        f[4] = ((res >> (w - 1)) & 1) != 0;
        f[5] = (sv > half - 1) || (sv < -half);
    endfunction

    task automatic run_op(input int o, input int s, input longint a, input longint b, input int ci);
        longint     eres;
        logic [5:0] ef;
        string      ctag;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 3'(o);
        op_size  = 2'(s);
        src_a    = 32'(a);
        src_b    = 32'(b);
        carry_in = 1'(ci);
        model(o, s, a, b, ci, eres, ef);
        if (o == 5 || o == 6) ef[0] = m_flags[0];
        m_flags = ef;
        if (o != 4) m_result = 32'(eres);
        @(negedge clk);
        op_valid = 1'b0;
        ctag = (o == 5 || o == 6) ? "R8" : (o == 7) ? "R11" : (o == 1 || o == 3) ? "R10" : "R3";
        chk((o == 4) ? "R9" : "R2", "result", res_data, m_result);
        chk("R1", "upper result bits", longint'(res_data) >> width_of(s), 0);
        chk(ctag, "carry", flag_out[0], ef[0]);
        chk("R4", "parity", flag_out[1], ef[1]);
        chk("R5", "adjust", flag_out[2], ef[2]);
        chk("R6", "zero", flag_out[3], ef[3]);
        chk("R6", "sign", flag_out[4], ef[4]);
        chk((o == 7) ? "R11" : "R7", "overflow", flag_out[5], ef[5]);
        chk("R8", "mask", flag_wr_mask, (o == 5 || o == 6) ? 6'h3E : 6'h3F);
        chk((o == 4) ? "R9" : "R12", "write strobe", res_wr, (o != 4));
        chk("R12", "valid", res_valid, 1);
    endtask

    function automatic longint corner(input int k, input int w);
        longint m    = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        case (k)
            0: return 0;
            1: return 1;
            2: return half - 1;
            3: return half;
            4: return m;
            5: return 'h0F;
            6: return 64'h5555_5555 & m;
            default: return 64'hAAAA_AAAA & m;
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk("R12", "reset result", res_data, 0);
        chk("R12", "reset flags", flag_out, 0);
        chk("R12", "reset mask", flag_wr_mask, 0);
        chk("R12", "reset valid", res_valid, 0);
        chk("R12", "reset strobe", res_wr, 0);

        // R9: byte compare 254 vs 17 -> cf0 of0 sf1 zf0
        run_op(2, 0, 1000, 1, 0);
        run_op(4, 0, 254, 17, 0);
        chk("R9", "cmp example carry", flag_out[0], 0);
        chk("R9", "cmp example overflow", flag_out[5], 0);
        chk("R9", "cmp example sign", flag_out[4], 1);
        chk("R9", "cmp example zero", flag_out[3], 0);

        // R12: idle cycles keep flags and clear mask/valid
        @(negedge clk);
        @(negedge clk);
        chk("R12", "idle flags held", flag_out, m_flags);
        chk("R12", "idle mask", flag_wr_mask, 0);
        chk("R12", "idle valid", res_valid, 0);
        chk("R12", "idle strobe", res_wr, 0);
        chk("R12", "idle result held", res_data, m_result);

        // R8: carry set, then inc/dec pass it through
        run_op(0, 0, 255, 1, 0);
        run_op(5, 0, 127, 0, 0);
        chk("R8", "inc kept carry", flag_out[0], 1);
        run_op(2, 0, 5, 1, 0);
        run_op(6, 0, 0, 0, 1);
        chk("R8", "dec kept carry", flag_out[0], 0);

        // R11: negate corners
        run_op(7, 0, 0, 0, 0);
        chk("R11", "neg zero carry", flag_out[0], 0);
        run_op(7, 1, 32'h0001_8000, 0, 0);
        chk("R11", "neg min overflow", flag_out[5], 1);

        // R10: 64-bit chain via two 32-bit steps
        run_op(0, 2, 32'hFFFF_FFFF, 1, 0);
        run_op(1, 2, 0, 0, flag_out[0]);
        chk("R10", "chained high word", res_data, 1);
        run_op(2, 3, 0, 1, 0);
        run_op(3, 3, 5, 0, flag_out[0]);
        chk("R10", "borrow high word", res_data, 4);

        // byte sweep with junk upper operand bits
        for (int ai = 0; ai < 256; ai += 5) begin
            for (int bi = 0; bi < 256; bi += 7) begin
                for (int o = 0; o < 8; o++) begin
                    logic [31:0] junk;
                    junk = 32'(ai * 40503 + bi * 977 + o * 131);
                    run_op(o, 0, longint'({junk[23:0], 8'(ai)}), longint'({junk[31:8], 8'(bi)}), (ai ^ bi ^ o) & 1);
                end
            end
        end

        // wider widths over corner values
        for (int s = 1; s < 4; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int o = 0; o < 8; o++) begin
                        int w;
                        longint ja, jb;
                        w  = width_of(s);
                        ja = (w < 32) ? (longint'(32'hDEAD_BEEF) << w) : 0;
                        jb = (w < 32) ? (longint'(32'h1234_5678) << w) : 0;
                        run_op(o, s, corner(i, w) | ja, corner(j, w) | jb, (i + j + o) & 1);
                    end
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule